// File: doc/BRIEF.md
# Upper-Memory Shadow Routing Decoder

This block decides where accesses to the legacy upper-memory window go. The window runs from 0xC0000 to 0xFFFFF. A memory controller presents a physical address, and the block answers with two bits. One says whether a read of that address is served from DRAM or passed on to the bus. The other says the same for a write. Seven attribute bytes hold the routing choices. In 0xC0000–0xEFFFF every 16 KB slice has its own read and write enable. The last 64 KB, 0xF0000–0xFFFFF, shares one pair of enables.

Software loads the attribute bytes through a byte-wide write port that uses a valid/ready handshake. The block never applies back-pressure: `cfg_ready` is high in every cycle, and a write is taken in any cycle where `cfg_valid` is high. A taken write that lands on an attribute byte raises `map_changed` for one cycle, so that caches or translation state downstream can be flushed. The routing answer is combinational from the address and the stored bytes.

Top module: `shadow_route_decoder`

## Requirements
- R1: After reset, all seven attribute bytes are zero. Every in-window address therefore routes both reads and writes to the bus (`rd_to_dram`=0, `wr_to_dram`=0), and `map_changed` is 0.
- R2: Attribute offsets 0x5A to 0x5F each cover two 16 KB slices. Slice k (address 0xC0000 + k·0x4000, k = 0..11) is covered by offset 0x5A + k/2. For even k the read enable is bit 0 and the write enable is bit 1. For odd k the read enable is bit 4 and the write enable is bit 5. A bit value of 1 selects DRAM.
- R3: Every address from 0xF0000 to 0xFFFFF uses offset 0x59. Bit 4 is the read enable and bit 5 is the write enable.
- R4: A taken write to offsets 0x59–0x5F replaces the whole byte at that offset. Bits that were set and are written as 0 become clear; the old and new values are not merged.
- R5: `map_changed` is high in the cycle after every taken write to offsets 0x59–0x5F. Back-to-back writes keep it high for one cycle per write. It is low after any cycle without such a write.
- R6: A write to any offset outside 0x59–0x5F changes no routing output and does not raise `map_changed`.
- R7: An address outside 0xC0000–0xFFFFF drives `addr_outside`=1, `rd_to_dram`=0 and `wr_to_dram`=0. This includes addresses with any bit above bit 19 set.
- R8: The routing outputs follow `mem_addr` in the same cycle. A taken write changes them from the first cycle after the clock edge that takes it.
- R9: `cfg_ready` is 1 in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid | input | 1 | Attribute write offered |
| cfg_ready | output | 1 | Write accepted (always 1) |
| cfg_offset | input | 8 | Configuration byte offset of the write |
| cfg_data | input | 8 | Byte to store |
| mem_addr | input | ADDR_W | Physical address to classify |
| rd_to_dram | output | 1 | Read of `mem_addr` goes to DRAM |
| wr_to_dram | output | 1 | Write of `mem_addr` goes to DRAM |
| addr_outside | output | 1 | `mem_addr` lies outside the window |
| map_changed | output | 1 | One-cycle pulse after an attribute update |

## Verification
Two things can happen in the same cycle: an attribute update, and a lookup of an address that the update affects. The bench provokes this by holding an address in slice 0xC0000 while it writes a new value for that slice's byte in the same cycle. In the cycle of the write, the routing bits must still show the old byte. After the edge they must show the new byte, and `map_changed` must rise in that same later cycle. Back-to-back updates are also driven, to check that the strobe stays high for one cycle per write and then drops.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;
  localparam int NUM_ATTR       = 7;
  localparam int IDX_W          = $clog2(NUM_ATTR);
  localparam logic [7:0] FIRST_OFF = 8'h59;
  localparam logic [7:0] LAST_OFF  = FIRST_OFF + 8'(NUM_ATTR - 1);
  localparam int SLICE_LSB      = 14;
  localparam int NUM_SPLIT      = 12;
  typedef logic [7:0] attr_byte_t;
endpackage

// File: rtl/shadow_attr_store.sv
module shadow_attr_store
  import shadow_route_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_valid,
  input  logic [7:0]                      wr_offset,
  input  logic [7:0]                      wr_data,
  output attr_byte_t [NUM_ATTR-1:0]       attr_q,
  output logic                            changed_q
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [7:0]       rel;

  assign hit = wr_valid && (wr_offset >= FIRST_OFF) && (wr_offset <= LAST_OFF);
  assign rel = wr_offset - FIRST_OFF;
  assign idx = rel[IDX_W-1:0];

  for (genvar g = 0; g < NUM_ATTR; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        attr_q[g] <= '0;
      else if (hit && (idx == IDX_W'(g)))
        attr_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) changed_q <= 1'b0;
    else        changed_q <= hit;
  end

  // R5: strobe follows each update
  p_strobe_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> changed_q);
  p_strobe_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !changed_q);
  // R6: no update, no change of stored bytes
  p_hold_on_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(attr_q));
  // R4: whole byte replaced
  p_byte_replaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> attr_q[$past(idx)] == $past(wr_data));
endmodule

// File: rtl/shadow_slice_lookup.sv
module shadow_slice_lookup
  import shadow_route_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]           addr,
  input  attr_byte_t [NUM_ATTR-1:0]   attr,
  output logic                        rd_en,
  output logic                        wr_en,
  output logic                        outside
);
  localparam int WIN_TOP = 20;
  logic [3:0] slice;
  logic       in_win;
  attr_byte_t sel;
  logic       hi_nib;

  assign slice = addr[SLICE_LSB+3:SLICE_LSB];

  if (ADDR_W > WIN_TOP) begin : g_wide
    assign in_win = (addr[ADDR_W-1:WIN_TOP] == '0) && (addr[19:18] == 2'b11);
  end else begin : g_narrow
    assign in_win = (addr[19:18] == 2'b11);
  end

  always_comb begin
    if (slice >= 4'(NUM_SPLIT)) begin
      sel    = attr[0];
      hi_nib = 1'b1;
    end else begin
      sel    = attr[1 + int'(slice[3:1])];
      hi_nib = slice[0];
    end
  end

  assign rd_en   = in_win && (hi_nib ? sel[4] : sel[0]);
  assign wr_en   = in_win && (hi_nib ? sel[5] : sel[1]);
  assign outside = !in_win;
endmodule

// File: rtl/shadow_route_decoder.sv
module shadow_route_decoder
  import shadow_route_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [7:0]        cfg_offset,
  input  logic [7:0]        cfg_data,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              rd_to_dram,
  output logic              wr_to_dram,
  output logic              addr_outside,
  output logic              map_changed
);
  attr_byte_t [NUM_ATTR-1:0] attr;

  assign cfg_ready = 1'b1;

  shadow_attr_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (cfg_valid && cfg_ready),
    .wr_offset (cfg_offset),
    .wr_data   (cfg_data),
    .attr_q    (attr),
    .changed_q (map_changed)
  );

  shadow_slice_lookup #(.ADDR_W(ADDR_W)) u_lookup (
    .addr    (mem_addr),
    .attr    (attr),
    .rd_en   (rd_to_dram),
    .wr_en   (wr_to_dram),
    .outside (addr_outside)
  );

  // R7: outside the window nothing is routed to DRAM
  p_outside_no_dram_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_outside |-> (!rd_to_dram && !wr_to_dram));
  // R9: the port never stalls
  p_ready_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> cfg_ready);
endmodule

// File: tb/test_shadow_route_decoder.sv
module test_shadow_route_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_valid;
  logic        cfg_ready;
  logic [7:0]  cfg_offset;
  logic [7:0]  cfg_data;
  logic [31:0] mem_addr;
  logic        rd_to_dram, wr_to_dram, addr_outside, map_changed;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  shadow_route_decoder i_shadow_route_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_offset(cfg_offset), .cfg_data(cfg_data), .mem_addr(mem_addr),
    .rd_to_dram(rd_to_dram), .wr_to_dram(wr_to_dram),
    .addr_outside(addr_outside), .map_changed(map_changed)
  );

  // {offset, data, probe address, rd, wr, outside}; writes accumulate
  localparam logic [38:0] VEC [12] = '{
    {8'h5A, 8'h01, 20'hC0000, 3'b100},
    {8'h5A, 8'h23, 20'hC4000, 3'b010},
    {8'h5B, 8'h30, 20'hCC000, 3'b110},
    {8'h5B, 8'h30, 20'hC8123, 3'b000},
    {8'h5F, 8'h12, 20'hEC000, 3'b100},
    {8'h5F, 8'h12, 20'hE8000, 3'b010},
    {8'h59, 8'h30, 20'hF0000, 3'b110},
    {8'h59, 8'h10, 20'hFFFFF, 3'b100},
    {8'h5C, 8'h03, 20'hD3FFF, 3'b110},
    {8'h5D, 8'h20, 20'hDC000, 3'b010},
    {8'h5E, 8'h10, 20'hE4000, 3'b100},
    {8'h5E, 8'h10, 20'hBFFFF, 3'b001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic route(input string req, input logic [31:0] a, input logic [2:0] exp);
    mem_addr = a;
    #1;
    check(req, {29'd0, rd_to_dram, wr_to_dram, addr_outside}, {29'd0, exp});
  endtask

  // drives at a negedge; returns at the next negedge, after the edge that took it
  task automatic cfg_write(input logic [7:0] off, input logic [7:0] d);
    cfg_valid = 1'b1; cfg_offset = off; cfg_data = d;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_valid = 1'b0; cfg_offset = '0; cfg_data = '0; mem_addr = 32'hC0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 strobe", {31'd0, map_changed}, 32'd0);
    route("R1 C0000", 32'hC0000, 3'b000);
    route("R1 F8000", 32'hF8000, 3'b000);
    check("R9 ready", {31'd0, cfg_ready}, 32'd1);

    // table walk: R2 split slices, R3 shared top, R4 replace, R7 outside
    for (int i = 0; i < 12; i++) begin
      cfg_write(VEC[i][38:31], VEC[i][30:23]);
      #1;
      check("R5 strobe", {31'd0, map_changed}, 32'd1);
      route("R2/R3 table", {12'd0, VEC[i][22:3]}, VEC[i][2:0]);
    end
    // R4: 0x5A was 0x01 then 0x23, 0x59 was 0x30 then 0x10: wr bit cleared
    route("R4 F0000", 32'hF0000, 3'b100);
    route("R2 C0000", 32'hC0000, 3'b110);

    // R6: writes to neighbour offsets are ignored
    @(negedge clk);
    check("R5 quiet", {31'd0, map_changed}, 32'd0);
    cfg_write(8'h58, 8'hFF);
    #1; check("R6 strobe 58", {31'd0, map_changed}, 32'd0);
    route("R6 F0000", 32'hF0000, 3'b100);
    cfg_write(8'h60, 8'hFF);
    #1; check("R6 strobe 60", {31'd0, map_changed}, 32'd0);
    route("R6 E8000", 32'hE8000, 3'b010);

    // R7: bits above 19 set
    route("R7 high", 32'h100000, 3'b001);
    route("R7 low", 32'h0, 3'b001);

    // R8: write and lookup in the same cycle
    @(negedge clk);
    mem_addr = 32'hC0000;
    cfg_valid = 1'b1; cfg_offset = 8'h5A; cfg_data = 8'h00;
    #1;
    check("R8 old value", {30'd0, rd_to_dram, wr_to_dram}, 32'd3);
    @(negedge clk);
    cfg_valid = 1'b0;
    #1;
    check("R8 new value", {30'd0, rd_to_dram, wr_to_dram}, 32'd0);
    check("R5 same-cycle strobe", {31'd0, map_changed}, 32'd1);

    // R5: back-to-back writes
    @(negedge clk);
    cfg_valid = 1'b1; cfg_offset = 8'h5C; cfg_data = 8'h00;
    @(negedge clk);
    cfg_offset = 8'h5D; cfg_data = 8'h00;
    #1; check("R5 b2b first", {31'd0, map_changed}, 32'd1);
    @(negedge clk);
    cfg_valid = 1'b0;
    #1; check("R5 b2b second", {31'd0, map_changed}, 32'd1);
    @(negedge clk);
    #1; check("R5 b2b drop", {31'd0, map_changed}, 32'd0);

    // R1: reset again clears state
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 ready in reset", {31'd0, cfg_ready}, 32'd1);
    rst_n = 1'b1;
    route("R1 F0000 after reset", 32'hF0000, 3'b000);
    route("R1 EC000 after reset", 32'hEC000, 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule